// File: doc/BRIEF.md
# E1 Timeslot-0 National Bit Buffers

This block stores the national (Sa) bits that an E1 line carries in timeslot 0 of the frames without the alignment word, spread over the sixteen frames of a CRC-4 multiframe. Only the odd frames 1 to 15 carry these bits. Each of the five Sa positions, Sa4 to Sa8, owns one byte in each direction, and the eight bits of that byte stand for the eight odd frames.

On the receive side, the block samples the serial timeslot-0 bit stream and builds a shadow copy of the five bytes. It moves that copy into the readable buffers in one step, at the last bit of frame 15. It raises sticky flags when a multiframe starts, when an Sa5..Sa8 bit differs from its value in the previous odd frame, and when a nibble of a committed Sa5..Sa8 byte changes. Each flag has a mask bit, and the unmasked flags drive one interrupt line.

On the transmit side, the block puts the stored Sa bits into the outgoing timeslot-0 byte. A per-bit transparency mask can pass the incoming channel-0 bit through instead. Sa positions assigned to the data link take the external data-link bit and override both of these sources. A host reaches the registers through a plain write strobe and an address-decoded read.

Top module: `nb_e1_natbits`

## Requirements
- R1: In the strobed timeslot-0 byte, bits are sent MSB first: `bit_pos` counts 7 down to 0. In an odd frame f, the byte bit at position 4-i carries Sa(4+i), for i = 0..4. After the multiframe commits, that bit lands in bit (f-1)/2 of receive buffer i, which is read at address 5+i. Even frames and byte positions 7..5 are never captured.
- R2: The receive buffers change only in the cycle after the strobe at frame 15, position 0. A partial multiframe leaves the values read back unchanged.
- R3: While the strobe is high in an odd frame at positions 4..0, `tx_bit` is transmit buffer i (address i), bit (f-1)/2. At every other position, in every even frame, and whenever the strobe is low, `tx_bit` equals `ch0_in`.
- R4: When bit i of the transparency register (address 10) is set, the Sa(4+i) slot carries `ch0_in` instead of the buffer bit.
- R5: When bit i of the data-link select register (address 11) is set, the Sa(4+i) slot carries `dl_bit` and `dl_take` is high. This overrides both the buffer and the transparency mask. Outside such slots `dl_take` is low.
- R6: The strobe at frame 0, position 7 sets flag bit 0 of the first flag register (address 12), which marks the multiframe start.
- R7: Flag bits 1..4 of address 12 are set when the received Sa5..Sa8 bit of an odd frame differs from the same Sa bit of the previous odd frame. The stored previous value is 0 after reset.
- R8: At the frame-15 commit, flag register 2 (address 13) sets bit 2j for a change in the low nibble (frames 1..7) and bit 2j+1 for a change in the high nibble of Sa(5+j), j = 0..3. The new byte is compared with the byte previously committed.
- R9: Flags stay set until a 1 is written to their bit. Writing 0 has no effect. If a clear and a set event fall in the same cycle, the flag ends up set.
- R10: `irq` is high exactly when some flag is set whose mask bit is also set. Address 14 masks flag register 1 and address 15 masks flag register 2.
- R11: After reset, every register reads 0, `irq` is low, and `tx_bit` follows `ch0_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ts0_stb | input | 1 | High for each bit time of timeslot 0 |
| frame_idx | input | 4 | Frame number within the multiframe, 0..15 |
| bit_pos | input | 3 | Bit position in the timeslot-0 byte, 7 sent first |
| rx_bit | input | 1 | Received timeslot-0 bit |
| ch0_in | input | 1 | Channel-0 bit from the outgoing data stream |
| dl_bit | input | 1 | Data-link bit to insert |
| tx_bit | output | 1 | Transmitted timeslot-0 bit |
| dl_take | output | 1 | The data-link bit is being consumed in this bit time |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | OR of the unmasked flags |

## Verification
Two things can land on the same clock edge: a host write-1-to-clear on a flag register, and a receive event that sets a flag in that same register. The bench provokes this by issuing the clearing write in the exact cycle that carries frame 0, position 7, where the multiframe-start flag is set. It then reads the flag back, and the flag must still be set. Commit and capture also coincide at frame 15, position 0, where the last Sa8 bit has to appear in the committed byte. The bench checks this through the receive buffer readback and the nibble flags.

// File: rtl/nb_pkg.sv
package nb_pkg;
  localparam int NSA   = 5;
  localparam int BUF_W = 8;
  localparam int FRM_W = 4;
  localparam int POS_W = 3;

  typedef logic [BUF_W-1:0] sa_byte_t;

  // Sa slots occupy byte positions 4..0 of timeslot 0
  function automatic logic is_sa_pos(input logic [POS_W-1:0] p);
    return p <= POS_W'(NSA - 1);
  endfunction

  // Sa4 -> index 0 at position 4, Sa8 -> index 4 at position 0
  function automatic logic [POS_W-1:0] sa_of_pos(input logic [POS_W-1:0] p);
    return POS_W'(NSA - 1) - p;
  endfunction

  // odd frame 1,3,..,15 -> buffer bit 0..7
  function automatic logic [2:0] odd_slot(input logic [FRM_W-1:0] f);
    return f[3:1];
  endfunction

  // {high nibble changed, low nibble changed}
  function automatic logic [1:0] nib_diff(input sa_byte_t a, input sa_byte_t b);
    return {a[7:4] != b[7:4], a[3:0] != b[3:0]};
  endfunction
endpackage

// File: rtl/nb_rx_capture.sv
module nb_rx_capture
  import nb_pkg::*;
#(
  parameter int N = NSA,
  localparam int NIB_W = 2 * (N - 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ts0_stb,
  input  logic [FRM_W-1:0]     frame_idx,
  input  logic [POS_W-1:0]     bit_pos,
  input  logic                 rx_bit,
  output logic [N-1:0][BUF_W-1:0] rx_buf,
  output logic                 mf_evt,
  output logic                 commit_evt,
  output logic [N-2:0]         bitcos_evt,
  output logic [NIB_W-1:0]     nibcos_evt
);
  logic [N-1:0][BUF_W-1:0] shadow, shadow_nx;
  logic [N-1:0]            prev_bit;
  logic                    cap_en;
  logic [POS_W-1:0]        sidx;
  logic [2:0]              kslot;

  assign sidx       = sa_of_pos(bit_pos);
  assign kslot      = odd_slot(frame_idx);
  assign cap_en     = ts0_stb && frame_idx[0] && is_sa_pos(bit_pos);
  assign commit_evt = ts0_stb && (frame_idx == 4'd15) && (bit_pos == 3'd0);
  assign mf_evt     = ts0_stb && (frame_idx == 4'd0) && (bit_pos == 3'd7);

  always_comb begin
    shadow_nx = shadow;
    if (cap_en) shadow_nx[sidx][kslot] = rx_bit;
  end

  for (genvar g = 1; g < N; g++) begin : g_cos
    assign bitcos_evt[g-1] = cap_en && (sidx == POS_W'(g)) && (rx_bit != prev_bit[g]);
    assign nibcos_evt[2*(g-1) +: 2] = commit_evt ? nib_diff(rx_buf[g], shadow_nx[g]) : 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow   <= '0;
      rx_buf   <= '0;
      prev_bit <= '0;
    end else begin
      shadow <= shadow_nx;
      if (cap_en) prev_bit[sidx] <= rx_bit;
      if (commit_evt) rx_buf <= shadow_nx;
    end
  end

  a_r2_atomic_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_evt |=> $stable(rx_buf));
  a_r1_last_bit_lands: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> rx_buf[N-1][BUF_W-1] == $past(rx_bit));
  a_r8_nib_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_evt |-> nibcos_evt == '0);
endmodule

// File: rtl/nb_tx_insert.sv
module nb_tx_insert
  import nb_pkg::*;
#(
  parameter int N = NSA
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ts0_stb,
  input  logic [FRM_W-1:0]        frame_idx,
  input  logic [POS_W-1:0]        bit_pos,
  input  logic                    ch0_in,
  input  logic                    dl_bit,
  input  logic [N-1:0][BUF_W-1:0] tx_buf,
  input  logic [N-1:0]            transp,
  input  logic [N-1:0]            dl_sel,
  output logic                    tx_bit,
  output logic                    dl_take
);
  logic             sa_slot;
  logic [POS_W-1:0] s;
  logic [2:0]       k;

  assign sa_slot = ts0_stb && frame_idx[0] && is_sa_pos(bit_pos);
  assign s       = sa_of_pos(bit_pos);
  assign k       = odd_slot(frame_idx);
  assign dl_take = sa_slot && dl_sel[s];

  always_comb begin
    if (!sa_slot)       tx_bit = ch0_in;
    else if (dl_sel[s]) tx_bit = dl_bit;
    else if (transp[s]) tx_bit = ch0_in;
    else                tx_bit = tx_buf[s][k];
  end

  a_r5_dl_wins: assert property (@(posedge clk) disable iff (!rst_n)
    dl_take |-> tx_bit == dl_bit);
  a_r3_even_frame_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (ts0_stb && !frame_idx[0]) |-> (tx_bit == ch0_in && !dl_take));
endmodule

// File: rtl/nb_irq_flags.sv
module nb_irq_flags #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  input  logic [W-1:0] mask,
  output logic [W-1:0] flags,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_vec) | set_vec;
  end

  assign irq = |(flags & mask);

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> (flags & $past(set_vec)) == $past(set_vec));
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags & ~clr_vec)) |=> (flags & $past(flags & ~clr_vec)) == $past(flags & ~clr_vec));
  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|flags));
endmodule

// File: rtl/nb_e1_natbits.sv
module nb_e1_natbits
  import nb_pkg::*;
#(
  parameter int N = NSA,
  localparam int NIB_W = 2 * (N - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ts0_stb,
  input  logic [FRM_W-1:0] frame_idx,
  input  logic [POS_W-1:0] bit_pos,
  input  logic             rx_bit,
  input  logic             ch0_in,
  input  logic             dl_bit,
  output logic             tx_bit,
  output logic             dl_take,
  input  logic             reg_wr,
  input  logic [3:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             irq
);
  localparam logic [3:0] A_RXB  = 4'd5;
  localparam logic [3:0] A_TRN  = 4'd10;
  localparam logic [3:0] A_DLS  = 4'd11;
  localparam logic [3:0] A_FLA  = 4'd12;
  localparam logic [3:0] A_FLB  = 4'd13;
  localparam logic [3:0] A_MSKA = 4'd14;
  localparam logic [3:0] A_MSKB = 4'd15;

  logic [N-1:0][BUF_W-1:0] tx_buf, rx_buf;
  logic [N-1:0]            transp, dl_sel, mask_a, flags_a, clr_a, set_a;
  logic [NIB_W-1:0]        mask_b, flags_b, clr_b, nibcos_evt;
  logic [N-2:0]            bitcos_evt;
  logic                    mf_evt, commit_evt, irq_a, irq_b;

  nb_rx_capture #(.N(N)) u_rx (
    .clk, .rst_n, .ts0_stb, .frame_idx, .bit_pos, .rx_bit,
    .rx_buf, .mf_evt, .commit_evt, .bitcos_evt, .nibcos_evt
  );

  nb_tx_insert #(.N(N)) u_tx (
    .clk, .rst_n, .ts0_stb, .frame_idx, .bit_pos, .ch0_in, .dl_bit,
    .tx_buf, .transp, .dl_sel, .tx_bit, .dl_take
  );

  assign set_a = {bitcos_evt, mf_evt};
  assign clr_a = (reg_wr && reg_addr == A_FLA) ? reg_wdata[N-1:0] : '0;
  assign clr_b = (reg_wr && reg_addr == A_FLB) ? reg_wdata[NIB_W-1:0] : '0;

  nb_irq_flags #(.W(N)) u_fla (
    .clk, .rst_n, .set_vec(set_a), .clr_vec(clr_a), .mask(mask_a),
    .flags(flags_a), .irq(irq_a)
  );
  nb_irq_flags #(.W(NIB_W)) u_flb (
    .clk, .rst_n, .set_vec(nibcos_evt), .clr_vec(clr_b), .mask(mask_b),
    .flags(flags_b), .irq(irq_b)
  );

  assign irq = irq_a | irq_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf <= '0;
      transp <= '0;
      dl_sel <= '0;
      mask_a <= '0;
      mask_b <= '0;
    end else if (reg_wr) begin
      if (reg_addr < A_RXB) tx_buf[reg_addr[2:0]] <= reg_wdata;
      case (reg_addr)
        A_TRN:   transp <= reg_wdata[N-1:0];
        A_DLS:   dl_sel <= reg_wdata[N-1:0];
        A_MSKA:  mask_a <= reg_wdata[N-1:0];
        A_MSKB:  mask_b <= reg_wdata[NIB_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr < A_RXB)      reg_rdata = tx_buf[reg_addr[2:0]];
    else if (reg_addr < A_TRN) reg_rdata = rx_buf[3'(reg_addr - A_RXB)];
    else begin
      case (reg_addr)
        A_TRN:   reg_rdata[N-1:0]     = transp;
        A_DLS:   reg_rdata[N-1:0]     = dl_sel;
        A_FLA:   reg_rdata[N-1:0]     = flags_a;
        A_FLB:   reg_rdata[NIB_W-1:0] = flags_b;
        A_MSKA:  reg_rdata[N-1:0]     = mask_a;
        A_MSKB:  reg_rdata[NIB_W-1:0] = mask_b;
        default: ;
      endcase
    end
  end

  a_r6_mf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    mf_evt |=> flags_a[0]);
  a_r10_irq_zero_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_a == '0 && mask_b == '0) |-> !irq);
endmodule

// File: tb/nb_e1_natbits_tb.sv
module nb_e1_natbits_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ts0_stb = 0, rx_bit = 0, ch0_in = 0, dl_bit = 0, reg_wr = 0;
  logic [3:0] frame_idx = 0, reg_addr = 0;
  logic [2:0] bit_pos = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic tx_bit, dl_take, irq;

  always #5 clk = ~clk;

  nb_e1_natbits u_dut (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model
  logic [7:0] m_shadow [5], m_rx [5], m_txb [5], sab [5];
  logic [4:0] m_prev, m_fa, m_transp, m_dls;
  logic [7:0] m_fb;
  logic [7:0] tx_got [16], dl_got [16];
  logic [7:0] ch0_pat;
  bit sc_en = 0;
  logic [3:0] sc_frame;
  logic [2:0] sc_pos;
  logic [3:0] sc_addr;
  logic [7:0] sc_data;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_clear(input logic [3:0] a, input logic [7:0] d);
    if (a == 4'd12) m_fa &= ~d[4:0];
    if (a == 4'd13) m_fb &= ~d;
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
    model_clear(a, d);
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [7:0] rx_byte(input logic [3:0] f);
    logic [7:0] b = 8'hB4 ^ {f, f};
    if (f[0]) for (int i = 0; i < 5; i++) b[4-i] = sab[i][f[3:1]];
    return b;
  endfunction

  task automatic send_frame(input logic [3:0] f);
    logic [7:0] rb = rx_byte(f);
    for (int p = 7; p >= 0; p--) begin
      bit w = sc_en && sc_frame == f && sc_pos == 3'(p);
      ts0_stb = 1; frame_idx = f; bit_pos = 3'(p);
      rx_bit = rb[p]; ch0_in = ch0_pat[p];
      if (w) begin reg_wr = 1; reg_addr = sc_addr; reg_wdata = sc_data; end
      #2;
      tx_got[f][p] = tx_bit; dl_got[f][p] = dl_take;
      @(posedge clk); #1;
      ts0_stb = 0; reg_wr = 0;
      if (w) model_clear(sc_addr, sc_data);
      if (f == 0 && p == 7) m_fa[0] = 1'b1;
      if (f[0] && p <= 4) begin
        int i = 4 - p;
        m_shadow[i][f[3:1]] = rb[p];
        if (i >= 1 && rb[p] != m_prev[i]) m_fa[i] = 1'b1;
        m_prev[i] = rb[p];
      end
      if (f == 15 && p == 0) begin
        for (int j = 0; j < 4; j++) begin
          if (m_rx[j+1][3:0] != m_shadow[j+1][3:0]) m_fb[2*j] = 1'b1;
          if (m_rx[j+1][7:4] != m_shadow[j+1][7:4]) m_fb[2*j+1] = 1'b1;
        end
        for (int i = 0; i < 5; i++) m_rx[i] = m_shadow[i];
      end
    end
  endtask

  task automatic send_frames(input int first, input int last);
    for (int f = first; f <= last; f++) send_frame(4'(f));
  endtask

  task automatic check_rx(input string tag);
    logic [7:0] d;
    for (int i = 0; i < 5; i++) begin
      reg_read(4'(5 + i), d);
      chk(tag, d, m_rx[i]);
    end
  endtask

  task automatic check_flags(input string tag);
    logic [7:0] d;
    reg_read(4'd12, d); chk(tag, d, {3'b0, m_fa});
    reg_read(4'd13, d); chk(tag, d, m_fb);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 16; a++) begin
      reg_read(4'(a), d);
      chk("R11 reset reg", d, 0);
    end
    chk("R11 irq reset", irq, 0);
    ch0_in = 1; #1; chk("R11 tx follows ch0", tx_bit, 1);
    ch0_in = 0; #1; chk("R11 tx follows ch0", tx_bit, 0);
  endtask

  task automatic t_rx_capture;
    logic [7:0] old [5];
    sab = '{8'hA5, 8'h3C, 8'h0F, 8'hF0, 8'h96};
    send_frames(0, 15);
    check_rx("R1 rx capture");
    check_flags("R6 R7 R8 flags after first mf");
    reg_write(4'd12, 8'h1F); reg_write(4'd13, 8'hFF);
    check_flags("R9 w1c clears");
    for (int i = 0; i < 5; i++) old[i] = m_rx[i];
    sab = '{8'h5A, 8'h3D, 8'hFF, 8'h00, 8'h81};
    send_frames(0, 9);
    check_rx("R2 partial mf keeps buffers");
    for (int i = 0; i < 5; i++) chk("R2 unchanged vs prior", m_rx[i], old[i]);
    send_frames(10, 15);
    check_rx("R1 rx second mf");
    check_flags("R7 R8 flags second mf");
  endtask

  task automatic t_irq;
    chk("R10 masked flags no irq", irq, 0);
    reg_write(4'd15, 8'h02);
    chk("R10 nibble mask irq", irq, m_fb[1]);
    reg_write(4'd15, 8'h00); reg_write(4'd14, 8'h01);
    chk("R10 mf mask irq", irq, m_fa[0]);
    reg_write(4'd12, 8'h00);
    check_flags("R9 write zero keeps flags");
    reg_write(4'd12, 8'h1F); reg_write(4'd13, 8'hFF);
    chk("R10 irq after clear", irq, 0);
    reg_write(4'd14, 8'h00);
  endtask

  task automatic t_tx(input logic [4:0] trn, input logic [4:0] dls, input logic dlb,
                      input string tag);
    logic [7:0] e;
    m_txb = '{8'hC3, 8'h1E, 8'h77, 8'h88, 8'h35};
    for (int i = 0; i < 5; i++) reg_write(4'(i), m_txb[i]);
    reg_write(4'd10, {3'b0, trn}); reg_write(4'd11, {3'b0, dls});
    m_transp = trn; m_dls = dls; dl_bit = dlb;
    ch0_pat = 8'h5A;
    send_frames(0, 15);
    for (int f = 0; f < 16; f++) begin
      e = ch0_pat;
      if (f[0]) for (int i = 0; i < 5; i++)
        e[4-i] = m_dls[i] ? dlb : (m_transp[i] ? ch0_pat[4-i] : m_txb[i][f>>1]);
      chk(tag, tx_got[f], e);
      chk("R5 dl_take pattern", dl_got[f], f[0] ? {3'b0, m_dls[0], m_dls[1], m_dls[2], m_dls[3], m_dls[4]} : 8'h00);
    end
    ch0_pat = 8'h00;
  endtask

  task automatic t_same_cycle;
    reg_write(4'd12, 8'h1F); reg_write(4'd13, 8'hFF);
    sc_en = 1; sc_frame = 4'd0; sc_pos = 3'd7; sc_addr = 4'd12; sc_data = 8'h01;
    send_frame(4'd0);
    sc_en = 0;
    check_flags("R9 set wins over clear");
    reg_write(4'd12, 8'h01);
    check_flags("R9 clear alone");
  endtask

  initial begin
    m_prev = 0; m_fa = 0; m_fb = 0; ch0_pat = 0;
    for (int i = 0; i < 5; i++) begin m_shadow[i] = 0; m_rx[i] = 0; sab[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_rx_capture();
    t_irq();
    t_tx(5'b00000, 5'b00000, 1'b0, "R3 buffer insertion");
    t_tx(5'b00101, 5'b00000, 1'b0, "R4 transparency");
    t_tx(5'b10101, 5'b10010, 1'b1, "R5 data link override");
    t_same_cycle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule